// File: doc/BRIEF.md
# 1-Wire Bit-Slot Timing Master

This block drives one open-drain 1-Wire line and generates the four primitive operations that higher layers build bytes and ROM commands from. The four operations are a reset pulse with presence detection, a write-zero slot, a write-one slot and a read slot. A caller requests one operation with a single-cycle strobe, an operation code and a speed select. While the slot runs, the block reports busy. At the end it pulses done and presents either the sampled bit or a presence status.

All slot timing is counted in microseconds. A free-running divider that restarts with every operation produces one tick per microsecond. There are two timing sets, one for standard speed and one for fast speed. Each set is held in writable registers. A write is accepted only when its value lies inside the legal range for that parameter. Otherwise the write is refused and an error pulse is raised. The read sample point cannot be written in either set.

Top module: `owire_slot_master`

## Requirements
- R1: After reset, `line_drive_low`, `busy` and `done` are 0, and `line_drive_low` is never 1 while `busy` is 0.
- R2: Write-zero (`cmd_op`=1) holds the line low for the write-zero low time. It then releases the line, and `busy` stays high for (max(slot, low time) + 1) us × CLK_PER_US + 1 cycles. The standard defaults are low 60 us and slot 60 us.
- R3: Write-one (`cmd_op`=2) holds the line low for the write-one low time (standard default 1 us). `busy` lasts (slot + 1) us × CLK_PER_US + 1 cycles.
- R4: Read (`cmd_op`=3) drives the line low for the read-start time (default 1 us). It samples the line during the microsecond that begins at the sample point: 15 us in standard speed, 2 us in fast speed. `rx_bit` shows the sampled value from the done cycle onward.
- R5: Reset (`cmd_op`=0) holds the line low for the reset-low time (default 480 us) and lasts reset-low + reset-high us. If the line is seen low anywhere in the window [release + presence-wait, release + presence-wait + presence-low), `presence` reports 2'b00 (device answered).
- R6: If a reset sees no low level in that window, `presence` reports 2'b01 (no device).
- R7: `presence` reports 2'b11 (miswired) in two cases. The first is when the line is low at the moment the reset is accepted; the line is then never driven and done follows in the next cycle. The second is when the line is still low 1 us after the reset-low phase ends.
- R8: `cmd_mode`=1 selects the fast timing set for that operation. Its defaults are slot 11, write-zero low 6, write-one low 1, sample 2, reset low 48, reset high 48, presence-low 8, presence-wait 2 and read-start 1 (all in us).
- R9: A configuration write with `cfg_sel` = 0 slot, 1 write-zero low, 2 write-one low, 4 reset low, 5 reset high, 6 presence-low, 7 presence-wait or 8 read-start is stored only if min ≤ value < max. The ranges are: standard slot 60..120, write-one low 1..15, presence-low 60..240; fast slot 6..16, reset low 48..80, presence-low 8..24, write-one low 1..2. Any other value raises `cfg_err` for one cycle and keeps the old value.
- R10: A write to `cfg_sel`=3 (sample point), or to an index above 8, is always refused with `cfg_err`, and the sample point is unchanged.
- R11: A strobe that arrives while `busy` is 1 is ignored: no second operation follows.
- R12: `done` is high for exactly one cycle, the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle operation strobe |
| cmd_op | input | 2 | 0 reset, 1 write-zero, 2 write-one, 3 read |
| cmd_mode | input | 1 | 0 standard timing, 1 fast timing |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_set | input | 1 | Timing set written: 0 standard, 1 fast |
| cfg_sel | input | 4 | Timing parameter index |
| cfg_data | input | 10 | New value in microseconds |
| cfg_err | output | 1 | Pulse: the last write was refused |
| line_in | input | 1 | Sensed level of the 1-Wire line |
| line_drive_low | output | 1 | 1 pulls the line low; 0 releases it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Bit sampled by the last read |
| presence | output | 2 | Reset outcome: 00 answered, 01 none, 11 miswired |

## Verification
Each slot type runs against a line model that either stays idle or answers at a chosen delay. Measured low and busy lengths separate the write-zero, write-one and read timings. Read responders that hold the line past the sample point, or release it before, show where the sample is taken. Reset runs use a responder inside the presence window, a responder that ends before the window, a line stuck low before the pulse, and a line held low after release, which covers all three outcomes. Legal and illegal register writes are followed by slots whose measured lengths show whether the stored value changed.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int TW   = 10;        // microsecond value width
  localparam int CW   = TW + 1;    // operation timer width
  localparam int NPAR = 9;

  typedef logic [TW-1:0] us_t;
  typedef logic [CW-1:0] ut_t;
  typedef logic [NPAR-1:0][TW-1:0] tset_t;

  localparam int P_SLOT   = 0;
  localparam int P_LOW0   = 1;
  localparam int P_LOW1   = 2;
  localparam int P_SAMPLE = 3;
  localparam int P_RSTL   = 4;
  localparam int P_RSTH   = 5;
  localparam int P_PDL    = 6;
  localparam int P_PDH    = 7;
  localparam int P_LOWR   = 8;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR0   = 2'd1,
    OP_WR1   = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  localparam logic [1:0] PRES_YES  = 2'b00;
  localparam logic [1:0] PRES_NONE = 2'b01;
  localparam logic [1:0] PRES_BAD  = 2'b11;

  typedef struct packed {
    us_t lo;
    us_t hi;
    us_t def;
  } lim_t;

  typedef struct packed {
    ut_t low;
    ut_t samp;
    ut_t fin;
    ut_t chk;
    ut_t wlo;
    ut_t whi;
  } plan_t;

  function automatic lim_t lim_of(input logic fast, input int idx);
    lim_t l;
    l = '{lo: us_t'(1), hi: us_t'(1), def: us_t'(1)};
    if (!fast) begin
      case (idx)
        P_SLOT:   l = '{lo: 60,  hi: 120, def: 60};
        P_LOW0:   l = '{lo: 60,  hi: 120, def: 60};
        P_LOW1:   l = '{lo: 1,   hi: 15,  def: 1};
        P_SAMPLE: l = '{lo: 15,  hi: 15,  def: 15};
        P_RSTL:   l = '{lo: 480, hi: 960, def: 480};
        P_RSTH:   l = '{lo: 480, hi: 960, def: 480};
        P_PDL:    l = '{lo: 60,  hi: 240, def: 60};
        P_PDH:    l = '{lo: 15,  hi: 60,  def: 60};
        P_LOWR:   l = '{lo: 1,   hi: 15,  def: 1};
        default:  l = '{lo: 1,   hi: 1,   def: 1};
      endcase
    end else begin
      case (idx)
        P_SLOT:   l = '{lo: 6,   hi: 16,  def: 11};
        P_LOW0:   l = '{lo: 6,   hi: 16,  def: 6};
        P_LOW1:   l = '{lo: 1,   hi: 2,   def: 1};
        P_SAMPLE: l = '{lo: 2,   hi: 2,   def: 2};
        P_RSTL:   l = '{lo: 48,  hi: 80,  def: 48};
        P_RSTH:   l = '{lo: 48,  hi: 960, def: 48};
        P_PDL:    l = '{lo: 8,   hi: 24,  def: 8};
        P_PDH:    l = '{lo: 2,   hi: 6,   def: 2};
        P_LOWR:   l = '{lo: 1,   hi: 2,   def: 1};
        default:  l = '{lo: 1,   hi: 1,   def: 1};
      endcase
    end
    return l;
  endfunction

  // The sample point and unknown indices never pass; others need lo <= v < hi.
  function automatic logic legal(input logic fast, input int idx, input us_t v);
    lim_t l;
    l = lim_of(fast, idx);
    return (idx != P_SAMPLE) && (idx < NPAR) && (v >= l.lo) && (v < l.hi);
  endfunction

  function automatic ut_t ext(input us_t v);
    return ut_t'(v);
  endfunction

  // Converts one timing set and an operation into absolute microsecond marks.
  function automatic plan_t plan_of(input op_e op, input tset_t t);
    plan_t p;
    ut_t slot;
    slot = ext(t[P_SLOT]);
    p = '0;
    p.samp = '1;
    case (op)
      OP_RESET: begin
        p.low = ext(t[P_RSTL]);
        p.fin = ext(t[P_RSTL]) + ext(t[P_RSTH]);
        p.chk = ext(t[P_RSTL]) + ut_t'(1);
        p.wlo = ext(t[P_RSTL]) + ext(t[P_PDH]);
        p.whi = ext(t[P_RSTL]) + ext(t[P_PDH]) + ext(t[P_PDL]);
      end
      OP_WR0: begin
        p.low = ext(t[P_LOW0]);
        p.fin = ((ext(t[P_LOW0]) > slot) ? ext(t[P_LOW0]) : slot) + ut_t'(1);
      end
      OP_WR1: begin
        p.low = ext(t[P_LOW1]);
        p.fin = slot + ut_t'(1);
      end
      default: begin
        p.low  = ext(t[P_LOWR]);
        p.samp = ext(t[P_SAMPLE]);
        p.fin  = slot + ut_t'(1);
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + DW'(1);
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(div_q) < CLK_PER_US)); // R2
endmodule

// File: rtl/owm_timing_regs.sv
module owm_timing_regs
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_set,
  input  logic [3:0] cfg_sel,
  input  us_t        cfg_data,
  output logic       cfg_err,
  output tset_t      std_set,
  output tset_t      fast_set
);
  tset_t bank [2];
  logic  accept;
  logic  err_q;

  assign accept  = cfg_we && legal(cfg_set, int'(cfg_sel), cfg_data);
  assign cfg_err = err_q;
  assign std_set  = bank[0];
  assign fast_set = bank[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cfg_we && !accept;
  end

  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar p = 0; p < NPAR; p++) begin : g_par
      localparam lim_t L = lim_of(s[0], p);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank[s][p] <= L.def;
        else if (accept && (cfg_set == s[0]) && (cfg_sel == 4'(p)))
          bank[s][p] <= cfg_data;
      end

      AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !accept) |=> $stable(bank[s][p])); // R9
    end
  end
endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_mode,
  input  tset_t      std_set,
  input  tset_t      fast_set,
  input  logic       line_in,
  input  logic       tick,
  output logic       restart,
  output logic       drive_low,
  output logic       busy,
  output logic       done,
  output logic       rx_bit,
  output logic [1:0] presence
);
  logic       busy_q, done_q, pre_bad_q, seen_q, stuck_q, bit_q, rx_q;
  logic [1:0] pres_q;
  op_e        op_q;
  plan_t      plan_q;
  ut_t        t_q;
  logic       accept;

  // Named events for the checks below.
  logic at_end, in_window, at_check, at_sample;

  assign accept    = cmd_valid && !busy_q;
  assign restart   = accept;
  assign at_end    = busy_q && !pre_bad_q && (t_q == plan_q.fin);
  assign in_window = (op_q == OP_RESET) && (t_q >= plan_q.wlo) && (t_q < plan_q.whi);
  assign at_check  = (op_q == OP_RESET) && (t_q == plan_q.chk);
  assign at_sample = (op_q == OP_READ) && (t_q == plan_q.samp);

  assign drive_low = busy_q && !pre_bad_q && (t_q < plan_q.low);
  assign busy      = busy_q;
  assign done      = done_q;
  assign rx_bit    = rx_q;
  assign presence  = pres_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; pre_bad_q <= 1'b0;
      seen_q <= 1'b0; stuck_q <= 1'b0; bit_q <= 1'b1; rx_q <= 1'b1;
      pres_q <= PRES_NONE; op_q <= OP_RESET; plan_q <= '0; t_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        t_q       <= '0;
        op_q      <= op_e'(cmd_op);
        plan_q    <= plan_of(op_e'(cmd_op), cmd_mode ? fast_set : std_set);
        pre_bad_q <= (op_e'(cmd_op) == OP_RESET) && !line_in;
        seen_q    <= 1'b0;
        stuck_q   <= 1'b0;
        bit_q     <= 1'b1;
      end else if (busy_q) begin
        if (pre_bad_q) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          pre_bad_q <= 1'b0;
          pres_q    <= PRES_BAD;
        end else if (at_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (op_q == OP_RESET)
            pres_q <= stuck_q ? PRES_BAD : (seen_q ? PRES_YES : PRES_NONE);
          if (op_q == OP_READ)
            rx_q <= bit_q;
        end else begin
          if (tick)                  t_q     <= t_q + ut_t'(1);
          if (at_sample)             bit_q   <= line_in;
          if (at_check && !line_in)  stuck_q <= 1'b1;
          if (in_window && !line_in) seen_q  <= 1'b1;
        end
      end
    end
  end

  AST_RELEASE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !drive_low) |=> !drive_low); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R12
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R12
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid) |=> $stable(op_q)); // R11
  AST_PRES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(pres_q)); // R5
endmodule

// File: rtl/owire_slot_master.sv
module owire_slot_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_mode,
  input  logic       cfg_we,
  input  logic       cfg_set,
  input  logic [3:0] cfg_sel,
  input  logic [9:0] cfg_data,
  output logic       cfg_err,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       busy,
  output logic       done,
  output logic       rx_bit,
  output logic [1:0] presence
);
  tset_t std_set, fast_set;
  logic  tick, restart;

  owm_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  owm_timing_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_err(cfg_err),
    .std_set(std_set), .fast_set(fast_set)
  );

  owm_slot_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mode(cmd_mode), .std_set(std_set), .fast_set(fast_set),
    .line_in(line_in), .tick(tick), .restart(restart),
    .drive_low(line_drive_low), .busy(busy), .done(done),
    .rx_bit(rx_bit), .presence(presence)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_drive_low); // R1
endmodule

// File: tb/test_owire_slot_master.sv
module test_owire_slot_master;
  localparam int C = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_mode = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cfg_we = 1'b0, cfg_set = 1'b0;
  logic [3:0] cfg_sel = 4'd0;
  logic [9:0] cfg_data = 10'd0;
  logic cfg_err, line_drive_low, busy, done, rx_bit;
  logic [1:0] presence;
  logic dev_pull = 1'b0, stuck = 1'b0, line_in;

  int total = 0, bad = 0;
  int m_low, m_busy, m_done;
  logic [1:0] m_pres;
  logic m_bit;

  // Responder settings, in microseconds
  int rel_wait = -1, rel_len = 0;   // reacts to line release
  int fall_len = -1;                // reacts to line fall (read answers)

  assign line_in = !(line_drive_low || dev_pull || stuck);

  always #2.5 clk = ~clk;

  owire_slot_master #(.CLK_PER_US(C)) i_owire_slot_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mode(cmd_mode), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_err(cfg_err),
    .line_in(line_in), .line_drive_low(line_drive_low), .busy(busy),
    .done(done), .rx_bit(rx_bit), .presence(presence)
  );

  always @(negedge line_drive_low) begin
    if (rel_wait >= 0) begin
      automatic int w = rel_wait, l = rel_len;
      fork begin
        repeat (w * C) @(posedge clk);
        #1 dev_pull = 1'b1;
        repeat (l * C) @(posedge clk);
        #1 dev_pull = 1'b0;
      end join_none
    end
  end

  always @(posedge line_drive_low) begin
    if (fall_len >= 0) begin
      automatic int l = fall_len;
      fork begin
        #1 dev_pull = 1'b1;
        repeat (l * C) @(posedge clk);
        #1 dev_pull = 1'b0;
      end join_none
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic md);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = md;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_low = 0; m_busy = 0; m_done = 0;
    for (int k = 0; k < 6000; k++) begin
      if (line_drive_low) m_low++;
      if (busy) m_busy++;
      if (done) begin m_done++; break; end
      @(negedge clk);
    end
    m_pres = presence;
    m_bit  = rx_bit;
    @(negedge clk);
    if (done) m_done++;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic s, input int sel, input int val, input int exp_err, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = s; cfg_sel = 4'(sel); cfg_data = 10'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    chk({tag, " cfg_err"}, int'(cfg_err), exp_err);
  endtask

  task automatic t_reset_state;
    chk("R1 drive after reset", int'(line_drive_low), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
  endtask

  task automatic t_writes;
    do_op(2'd1, 1'b0);
    chk("R2 write-zero low cycles", m_low, 60 * C);
    chk("R2 write-zero busy cycles", m_busy, 61 * C + 1);
    chk("R12 write-zero done pulses", m_done, 1);
    do_op(2'd2, 1'b0);
    chk("R3 write-one low cycles", m_low, 1 * C);
    chk("R3 write-one busy cycles", m_busy, 61 * C + 1);
  endtask

  task automatic t_reads;
    fall_len = 20;
    do_op(2'd3, 1'b0);
    chk("R4 read low cycles", m_low, 1 * C);
    chk("R4 read long hold bit", int'(m_bit), 0);
    fall_len = 10;
    do_op(2'd3, 1'b0);
    chk("R4 read short hold bit", int'(m_bit), 1);
    fall_len = -1;
    do_op(2'd3, 1'b0);
    chk("R4 read idle bit", int'(m_bit), 1);
  endtask

  task automatic t_resets;
    rel_wait = 30; rel_len = 100;
    do_op(2'd0, 1'b0);
    chk("R5 reset low cycles", m_low, 480 * C);
    chk("R5 reset busy cycles", m_busy, 960 * C + 1);
    chk("R5 presence answered", int'(m_pres), 0);
    rel_wait = 10; rel_len = 30;
    do_op(2'd0, 1'b0);
    chk("R6 presence none (early pulse)", int'(m_pres), 1);
    rel_wait = -1;
    do_op(2'd0, 1'b0);
    chk("R6 presence none (idle)", int'(m_pres), 1);
    stuck = 1'b1;
    do_op(2'd0, 1'b0);
    stuck = 1'b0;
    chk("R7 stuck before: presence", int'(m_pres), 3);
    chk("R7 stuck before: busy cycles", m_busy, 1);
    chk("R7 stuck before: low cycles", m_low, 0);
    rel_wait = 0; rel_len = 200;
    do_op(2'd0, 1'b0);
    rel_wait = -1;
    repeat (420 * C) @(negedge clk);
    chk("R7 stuck after release: presence", int'(m_pres), 3);
  endtask

  task automatic t_fast;
    do_op(2'd1, 1'b1);
    chk("R8 fast write-zero low", m_low, 6 * C);
    chk("R8 fast write-zero busy", m_busy, 12 * C + 1);
    fall_len = 4;
    do_op(2'd3, 1'b1);
    fall_len = -1;
    chk("R8 fast read bit", int'(m_bit), 0);
    rel_wait = 3; rel_len = 6;
    do_op(2'd0, 1'b1);
    rel_wait = -1;
    repeat (10 * C) @(negedge clk);
    chk("R8 fast reset low", m_low, 48 * C);
    chk("R8 fast reset busy", m_busy, 96 * C + 1);
    chk("R8 fast presence", int'(m_pres), 0);
  endtask

  task automatic t_config;
    cfg(1'b0, 0, 100, 0, "R9 std slot 100");
    do_op(2'd2, 1'b0);
    chk("R9 std slot 100 busy", m_busy, 101 * C + 1);
    cfg(1'b0, 0, 120, 1, "R9 std slot 120");
    do_op(2'd2, 1'b0);
    chk("R9 std slot kept", m_busy, 101 * C + 1);
    cfg(1'b0, 2, 15, 1, "R9 std write-one 15");
    cfg(1'b0, 2, 14, 0, "R9 std write-one 14");
    do_op(2'd2, 1'b0);
    chk("R9 std write-one 14 low", m_low, 14 * C);
    cfg(1'b1, 0, 5, 1, "R9 fast slot 5");
    cfg(1'b1, 0, 15, 0, "R9 fast slot 15");
    do_op(2'd2, 1'b1);
    chk("R9 fast slot 15 busy", m_busy, 16 * C + 1);
    cfg(1'b1, 4, 80, 1, "R9 fast reset-low 80");
    cfg(1'b0, 6, 240, 1, "R9 std presence-low 240");
    cfg(1'b0, 3, 20, 1, "R10 sample write");
    cfg(1'b0, 9, 20, 1, "R10 index 9");
    fall_len = 17;
    do_op(2'd3, 1'b0);
    fall_len = -1;
    chk("R10 sample point unchanged", int'(m_bit), 0);
  endtask

  task automatic t_busy_block;
    int extra;
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = 1'b0; cfg_sel = 4'd0; cfg_data = 10'd60;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_mode = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5 * C) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    extra = 0;
    for (int k = 0; k < 400; k++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      if (busy || line_drive_low) extra++;
      @(negedge clk);
    end
    chk("R11 no operation after ignored strobe", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fork
      begin
        t_writes();
        t_reads();
        t_resets();
        t_fast();
        t_config();
        t_busy_block();
      end
      begin
        repeat (150000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule